// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a dynamic memory's contents alive by issuing refresh cycles in which the column strobe falls before the row strobe. With that ordering the memory's own row counter picks the row, so the scheduler drives no address. A free-running interval timer adds one unit of refresh debt at each expiry. The interval is a parameter. At the default of 1560 cycles of a 100 MHz clock it spreads 4,096 refreshes across a 64 ms retention window, and a 13-row-bit memory that needs 8,192 refreshes simply halves it.

While debt is owed the block raises a request to the access controller. Once granted it takes over the row and column strobes and runs refresh cycles back to back, one for each unit of debt, until the debt is paid. It then drops its request. The controller may withhold the grant while busy, which lets debt build up. An urgent flag tells the controller that postponement has gone far enough. The controller may only take the grant back between cycles; a cycle that has started always runs to its end.

After reset the debt starts at eight, so the first grant produces eight initialisation refreshes before ready is reported. While `strobe_en` is high the controller's pin multiplexer must pass `ras_n` and `cas_n` to the memory and hold the write enable high. Address and output enable are don't-care during these cycles.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `ras_n` and `cas_n` are 1, `strobe_en` is 0, `ready` is 0, `urgent` is 0, `debt` equals INIT_REFRESH (8) and `req` is 1.
- R2: Debt increases by exactly one every INTERVAL_CYCLES clock cycles, counted from reset.
- R3: `req` is 1 exactly when debt is nonzero or a refresh cycle is in progress. With no grant, no cycle starts, `strobe_en` stays 0 and both strobes stay 1.
- R4: Within each refresh cycle, `cas_n` is low for exactly CAS_LEAD_CYC cycles (default 1) with `ras_n` still high. `ras_n` is then low for exactly RAS_LOW_CYC cycles (default 5) and rises in the same cycle as `cas_n`. At least PRECHARGE_CYC cycles (default 4) with both strobes high separate `ras_n` rising from the next fall of `cas_n`.
- R5: While the grant is held, refresh cycles follow one another with one idle cycle between them. Each completed cycle lowers the debt by one, and the block stops when the debt reaches zero.
- R6: `urgent` is 1 exactly when `ready` is 1 and debt is at least URGENT_LEVEL (8).
- R7: Debt saturates at 2^DEBT_W-1 (15 by default); further timer expiries leave it unchanged.
- R8: `ready` rises in the cycle in which the INIT_REFRESH-th refresh completes, and it stays 1 until the next reset.
- R9: A grant withdrawn while a cycle is in progress does not cut that cycle short, and no further cycle starts until the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grant | input | 1 | Controller grants the memory strobes to the scheduler |
| req | output | 1 | Scheduler asks for the memory strobes |
| urgent | output | 1 | Refresh debt has reached the urgent level |
| ready | output | 1 | Initialisation refreshes are complete |
| strobe_en | output | 1 | Scheduler is driving the strobes this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| debt | output | DEBT_W | Refreshes owed |

## Verification
The debt counter is visible on `debt`, so a wrong increment or decrement shows up at the ports within one cycle of the timer expiry or the completed cycle that caused it. A wrong sequencer state appears at once as a strobe order or pulse width that breaks the cycle shape on `ras_n` and `cas_n`, or as strobe activity while `strobe_en` is low. A wrong initialisation count shows up as `ready` rising after the wrong number of row-strobe pulses. A timer of the wrong period shows up within one interval as debt arriving one cycle early or late.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_CAS_LEAD  = 2'd1,
        SEQ_RAS_LOW   = 2'd2,
        SEQ_PRECHARGE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic drive;
        logic ras_n;
        logic cas_n;
    } strobe_t;

    // Bits needed to hold the value v, never fewer than one.
    function automatic int unsigned bits_for(input int unsigned v);
        int unsigned w;
        w = 1;
        while ((v >> w) != 0) w++;
        return w;
    endfunction

    // Pin levels for each sequencer phase.
    function automatic strobe_t strobe_for(input seq_state_e s);
        strobe_t o;
        unique case (s)
            SEQ_CAS_LEAD:  o = '{drive: 1'b1, ras_n: 1'b1, cas_n: 1'b0};
            SEQ_RAS_LOW:   o = '{drive: 1'b1, ras_n: 1'b0, cas_n: 1'b0};
            SEQ_PRECHARGE: o = '{drive: 1'b1, ras_n: 1'b1, cas_n: 1'b1};
            default:       o = '{drive: 1'b0, ras_n: 1'b1, cas_n: 1'b1};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int unsigned INTERVAL_CYCLES = 1560
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import cbr_refresh_pkg::*;

    localparam int unsigned CW = bits_for(INTERVAL_CYCLES - 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYCLES - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (count_q == LAST) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    assign tick = (count_q == LAST);

endmodule

// File: rtl/refresh_debt_ledger.sv
module refresh_debt_ledger #(
    parameter int unsigned DEBT_W       = 4,
    parameter int unsigned INIT_REFRESH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accrue,
    input  logic              repay,
    output logic [DEBT_W-1:0] debt,
    output logic              ready
);
    import cbr_refresh_pkg::*;

    localparam logic [DEBT_W-1:0] DEBT_MAX  = '1;
    localparam logic [DEBT_W-1:0] DEBT_INIT = DEBT_W'(INIT_REFRESH);

    logic [DEBT_W-1:0] debt_q;
    logic [DEBT_W-1:0] debt_d;

    always_comb begin
        debt_d = debt_q;
        unique case ({accrue, repay})
            2'b10: if (debt_q != DEBT_MAX) debt_d = debt_q + 1'b1;
            2'b01: if (debt_q != '0)       debt_d = debt_q - 1'b1;
            default: debt_d = debt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q <= DEBT_INIT;
        end else begin
            debt_q <= debt_d;
        end
    end

    assign debt = debt_q;

    generate
        if (INIT_REFRESH == 0) begin : g_no_init
            assign ready = 1'b1;
        end else begin : g_init
            localparam int unsigned IW = bits_for(INIT_REFRESH);
            localparam logic [IW-1:0] INIT_LOAD = IW'(INIT_REFRESH);
            logic [IW-1:0] init_left_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    init_left_q <= INIT_LOAD;
                end else if (repay && init_left_q != '0) begin
                    init_left_q <= init_left_q - 1'b1;
                end
            end

            assign ready = (init_left_q == '0);
        end
    endgenerate

endmodule

// File: rtl/cbr_strobe_sequencer.sv
module cbr_strobe_sequencer #(
    parameter int unsigned CAS_LEAD_CYC  = 1,
    parameter int unsigned RAS_LOW_CYC   = 5,
    parameter int unsigned PRECHARGE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    input  logic owed,
    output logic busy,
    output logic done,
    output logic strobe_en,
    output logic ras_n,
    output logic cas_n
);
    import cbr_refresh_pkg::*;

    localparam int unsigned LONGEST =
        (CAS_LEAD_CYC > RAS_LOW_CYC) ?
            ((CAS_LEAD_CYC > PRECHARGE_CYC) ? CAS_LEAD_CYC : PRECHARGE_CYC) :
            ((RAS_LOW_CYC > PRECHARGE_CYC) ? RAS_LOW_CYC : PRECHARGE_CYC);
    localparam int unsigned PW = bits_for(LONGEST);
    localparam logic [PW-1:0] LOAD_LEAD = PW'(CAS_LEAD_CYC - 1);
    localparam logic [PW-1:0] LOAD_RAS  = PW'(RAS_LOW_CYC - 1);
    localparam logic [PW-1:0] LOAD_PRE  = PW'(PRECHARGE_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [PW-1:0] left_q, left_d;
    logic          phase_end;
    strobe_t       pins;

    assign phase_end = (left_q == '0);

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (grant && owed) begin
                    state_d = SEQ_CAS_LEAD;
                    left_d  = LOAD_LEAD;
                end
            end
            SEQ_CAS_LEAD: begin
                if (phase_end) begin
                    state_d = SEQ_RAS_LOW;
                    left_d  = LOAD_RAS;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            SEQ_RAS_LOW: begin
                if (phase_end) begin
                    state_d = SEQ_PRECHARGE;
                    left_d  = LOAD_PRE;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            SEQ_PRECHARGE: begin
                if (phase_end) begin
                    state_d = SEQ_IDLE;
                    left_d  = '0;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                left_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    assign pins      = strobe_for(state_q);
    assign strobe_en = pins.drive;
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;
    assign busy      = (state_q != SEQ_IDLE);
    assign done      = (state_q == SEQ_PRECHARGE) && phase_end;

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
    parameter int unsigned INTERVAL_CYCLES = 1560,
    parameter int unsigned DEBT_W          = 4,
    parameter int unsigned URGENT_LEVEL    = 8,
    parameter int unsigned INIT_REFRESH    = 8,
    parameter int unsigned CAS_LEAD_CYC    = 1,
    parameter int unsigned RAS_LOW_CYC     = 5,
    parameter int unsigned PRECHARGE_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    output logic              req,
    output logic              urgent,
    output logic              ready,
    output logic              strobe_en,
    output logic              ras_n,
    output logic              cas_n,
    output logic [DEBT_W-1:0] debt
);
    localparam logic [DEBT_W-1:0] URGENT_D = DEBT_W'(URGENT_LEVEL);

    logic tick;
    logic busy;
    logic done;
    logic owed;

    refresh_interval_timer #(
        .INTERVAL_CYCLES(INTERVAL_CYCLES)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    refresh_debt_ledger #(
        .DEBT_W      (DEBT_W),
        .INIT_REFRESH(INIT_REFRESH)
    ) u_ledger (
        .clk   (clk),
        .rst   (rst),
        .accrue(tick),
        .repay (done),
        .debt  (debt),
        .ready (ready)
    );

    assign owed = (debt != '0);

    cbr_strobe_sequencer #(
        .CAS_LEAD_CYC (CAS_LEAD_CYC),
        .RAS_LOW_CYC  (RAS_LOW_CYC),
        .PRECHARGE_CYC(PRECHARGE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .grant    (grant),
        .owed     (owed),
        .busy     (busy),
        .done     (done),
        .strobe_en(strobe_en),
        .ras_n    (ras_n),
        .cas_n    (cas_n)
    );

    assign req    = owed || busy;
    assign urgent = ready && (debt >= URGENT_D);

endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
    parameter int unsigned DEBT_W      = 4,
    parameter int unsigned RAS_LOW_CYC = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              grant,
    input logic              req,
    input logic              ready,
    input logic              strobe_en,
    input logic              ras_n,
    input logic              cas_n,
    input logic [DEBT_W-1:0] debt
);
    localparam logic [DEBT_W-1:0] DEBT_MAX = '1;

    logic [7:0] ras_low_cnt;

    always_ff @(posedge clk) begin
        if (rst || ras_n) begin
            ras_low_cnt <= '0;
        end else begin
            ras_low_cnt <= ras_low_cnt + 1'b1;
        end
    end

    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    assert_ras_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (ras_low_cnt == 8'(RAS_LOW_CYC) && cas_n));

    assert_start_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_en) |-> $past(grant));

    assert_idle_pins_high_R3: assert property (@(posedge clk) disable iff (rst)
        !strobe_en |-> (ras_n && cas_n));

    assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> (debt == '0 && !strobe_en));

    assert_debt_step_R5: assert property (@(posedge clk) disable iff (rst)
        (debt == $past(debt)) || (debt == $past(debt) + 1'b1) || (debt + 1'b1 == $past(debt)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(debt) == DEBT_MAX) |-> (debt >= DEBT_MAX - 1'b1));

    assert_ready_sticks_R8: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
    .DEBT_W     (DEBT_W),
    .RAS_LOW_CYC(RAS_LOW_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .grant    (grant),
    .req      (req),
    .ready    (ready),
    .strobe_en(strobe_en),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .debt     (debt)
);

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;

    localparam int INTERVAL = 200;
    localparam int DW       = 4;
    localparam int URG      = 8;
    localparam int INIT     = 8;
    localparam int LEAD     = 1;
    localparam int RASC     = 5;
    localparam int PRE      = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          grant = 1'b0;
    logic          req, urgent, ready, strobe_en, ras_n, cas_n;
    logic [DW-1:0] debt;

    int checks = 0, fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int refresh_count = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    cbr_refresh_sched #(
        .INTERVAL_CYCLES(INTERVAL),
        .DEBT_W         (DW),
        .URGENT_LEVEL   (URG),
        .INIT_REFRESH   (INIT),
        .CAS_LEAD_CYC   (LEAD),
        .RAS_LOW_CYC    (RASC),
        .PRECHARGE_CYC  (PRE)
    ) u_cbr_refresh_sched (
        .clk      (clk),
        .rst      (rst),
        .grant    (grant),
        .req      (req),
        .urgent   (urgent),
        .ready    (ready),
        .strobe_en(strobe_en),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .debt     (debt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Strobe-shape monitor, sampled on the falling edge.
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    int   cas_lead = 0, ras_len = 0, high_run = 100;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ras && !ras_n) begin
                refresh_count++;
                mon_checks++;
                if (cas_lead != LEAD || cas_n) begin
                    mon_fails++;
                    $display("FAIL R4 cas lead before ras: actual %0d expected %0d", cas_lead, LEAD);
                end
            end
            if (!prev_ras && ras_n) begin
                mon_checks++;
                if (ras_len != RASC || !cas_n) begin
                    mon_fails++;
                    $display("FAIL R4 ras low width: actual %0d expected %0d", ras_len, RASC);
                end
            end
            if (prev_cas && !cas_n) begin
                mon_checks++;
                if (high_run < PRE) begin
                    mon_fails++;
                    $display("FAIL R4 precharge: actual %0d expected %0d", high_run, PRE);
                end
            end
            if (!strobe_en && !(ras_n && cas_n)) begin
                mon_checks++;
                mon_fails++;
                $display("FAIL R3 strobes active while not driving: actual %0d expected %0d",
                         {ras_n, cas_n}, 3);
            end
            if (!cas_n && ras_n) cas_lead++;
            else if (cas_n) cas_lead = 0;
            if (!ras_n) ras_len++;
            else ras_len = 0;
            if (ras_n && cas_n) high_run++;
            else high_run = 0;
        end
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    task automatic wait_until_debt(input int value, input int limit);
        for (int i = 0; i < limit && int'(debt) != value; i++) @(negedge clk);
    endtask

    task automatic drain(output int paid);
        int base;
        base = refresh_count;
        grant = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 400 && req; i++) @(negedge clk);
        grant = 1'b0;
        paid = refresh_count - base;
    endtask

    task automatic t_reset_r1;
        rst = 1'b1;
        grant = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
        check(!strobe_en && !ready && !urgent, "R1 flags low in reset",
              {strobe_en, ready, urgent}, 0);
        check(int'(debt) == INIT, "R1 initial debt", int'(debt), INIT);
        check(req, "R1 request after reset", req, 1);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(!strobe_en && ras_n && cas_n && refresh_count == 0,
              "R3 no activity without grant", refresh_count, 0);
        check(int'(debt) == INIT && req, "R3 request held while owed", int'(debt), INIT);
    endtask

    task automatic t_init_r8;
        int base;
        base = refresh_count;
        grant = 1'b1;
        for (int i = 0; i < 300 && !ready; i++) @(negedge clk);
        check(ready, "R8 ready rises", ready, 1);
        check(refresh_count - base == INIT, "R8 init refresh count", refresh_count - base, INIT);
        check(debt == '0 && !req, "R5 debt paid and request dropped",
              int'(debt) * 2 + int'(req), 0);
        repeat (5) @(negedge clk);
        check(!strobe_en && refresh_count - base == INIT, "R5 stops at zero debt",
              refresh_count - base, INIT);
        grant = 1'b0;
    endtask

    task automatic t_interval_r2;
        wait_until_debt(1, 400);
        check(int'(debt) == 1 && req && !strobe_en, "R3 tick raises request", int'(debt), 1);
        repeat (INTERVAL - 1) @(negedge clk);
        check(int'(debt) == 1, "R2 no tick before interval", int'(debt), 1);
        @(negedge clk);
        check(int'(debt) == 2, "R2 tick at interval", int'(debt), 2);
    endtask

    task automatic t_urgent_r6;
        int paid;
        wait_until_debt(URG - 1, 2000);
        check(!urgent && int'(debt) == URG - 1, "R6 not urgent below level", urgent, 0);
        wait_until_debt(URG, 400);
        check(urgent && req, "R6 urgent at level", urgent, 1);
        drain(paid);
        check(paid == URG, "R5 back-to-back drain count", paid, URG);
        check(debt == '0 && !urgent, "R6 urgent clears after drain", int'(debt), 0);
    endtask

    task automatic t_halt_r9;
        int base;
        wait_until_debt(2, 600);
        base = refresh_count;
        grant = 1'b1;
        for (int i = 0; i < 20 && !strobe_en; i++) @(negedge clk);
        grant = 1'b0;
        repeat (40) @(negedge clk);
        check(refresh_count - base == 1, "R9 started cycle completes, no more",
              refresh_count - base, 1);
        check(int'(debt) == 1 && req && !strobe_en, "R9 remaining debt held", int'(debt), 1);
        grant = 1'b1;
        for (int i = 0; i < 40 && req; i++) @(negedge clk);
        grant = 1'b0;
        check(debt == '0 && refresh_count - base == 2, "R9 resumes with grant",
              refresh_count - base, 2);
    endtask

    task automatic t_saturate_r7;
        int paid;
        repeat (17 * INTERVAL) @(negedge clk);
        check(int'(debt) == 15, "R7 debt saturates", int'(debt), 15);
        repeat (INTERVAL + 2) @(negedge clk);
        check(int'(debt) == 15 && urgent, "R7 stays saturated", int'(debt), 15);
        drain(paid);
        check(paid >= 15 && paid <= 16, "R5 saturated drain count", paid, 15);
        check(debt == '0 && ready, "R8 ready still high", int'(ready), 1);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks + mon_checks, fails + mon_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset_r1();
        t_init_r8();
        t_interval_r2();
        t_urgent_r6();
        t_halt_r9();
        t_saturate_r7();
        finish_run();
    end

endmodule